// File: doc/BRIEF.md
# Clocked Serial Master Channel

This block is a three-wire synchronous serial master. It drives a serial clock (`sck`) and shifts one word out on `so` while it shifts one word in from `si`. A host loads transmit words through a one-deep buffer with a write strobe. It collects received words from a holding register with a read strobe. The host can also watch a single-cycle interrupt pulse.

The host sets these options at run time: word length of seven or eight bits, bit order, clock inversion, data phase (normal or half a clock early), and transfer mode (single or continuous). The serial clock rate is set by a power-of-two prescaler followed by a divide-by-(N+1) counter. One error is detected: overrun. It sets a sticky flag when a word completes and the previous received word has not been read.

The controller has three states:
- `ST_IDLE`: `sck` rests at its idle level.
- `ST_ACTIVE`: `sck` is away from its idle level.
- `ST_REST`: `sck` is back at its idle level during a transfer.

Its transitions are:
- IDLE→ACTIVE: start, normal phase.
- IDLE→REST: start, early phase. This is the half-period setup before the first edge.
- ACTIVE→REST and REST→ACTIVE: each half-period tick.
- Word end→IDLE: the buffer is empty, or the mode is single.
- Word end→ACTIVE or REST: continuous mode with the buffer refilled. No idle cycle is inserted.

Top module: `serial_master_chan`

## Requirements
- R1: Every `sck` half-period during a transfer lasts exactly 2^P × (N+1) clock cycles, with P = `cfg_prescale` (0..15) and N = `cfg_divider`. With the fast option enabled, N = 0 gives a half-period of one clock.
- R2: While `busy` is low, `sck` equals `cfg_clk_inv`. After a transfer, `so` keeps the last bit it sent.
- R3: The word length is 8 bits when `cfg_len7` = 0 and 7 bits when it is 1. With `cfg_lsb_first` = 0, bit W-1 travels first; with 1, bit 0 travels first. Received bits are placed by the same rule. In 7-bit mode, `rx_rdata[7]` reads 0.
- R4: With `cfg_early` = 0, the clock's first leading edge comes in the same cycle `busy` rises. `so` changes together with each leading edge, and `si` is captured at each trailing edge.
- R5: With `cfg_early` = 1, the first bit appears on `so` one half-period before the first leading edge. `si` is captured at each leading edge, and `so` advances on each trailing edge.
- R6: In single mode (`cfg_continuous` = 0), `irq` is high for exactly one cycle. That cycle is the one in which `busy` falls at the end of a word.
- R7: In continuous mode, `irq` is high for exactly one cycle, in the cycle in which `tx_full` falls. A word that is buffered when the current word ends starts with no drop of `busy` and no gap in the half-period timing.
- R8: A `tx_wr` is accepted only while `tx_full` is 0. A write made while it is 1 is ignored.
- R9: A finished word sets `rx_valid` and is copied to `rx_rdata`, and `rx_rd` clears `rx_valid`. If a word finishes while `rx_valid` is 1 and `rx_rd` is 0, `ovr_flag` is set and the new word replaces the old one. `ovr_flag` stays set until `ovr_clr` is pulsed.
- R10: After reset, the channel is idle with `so`, `irq`, `tx_full`, `rx_valid` and `ovr_flag` all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len7 | input | 1 | 1 selects a 7-bit word, 0 selects an 8-bit word |
| cfg_lsb_first | input | 1 | 1 sends bit 0 first |
| cfg_clk_inv | input | 1 | Idle level of the serial clock |
| cfg_early | input | 1 | 1 presents data half a clock before the first edge |
| cfg_continuous | input | 1 | 1 selects continuous mode |
| cfg_prescale | input | 4 | Power-of-two prescale exponent |
| cfg_divider | input | 7 | Divider value N; each half-period counts N+1 prescaled ticks |
| tx_wr | input | 1 | Transmit write strobe |
| tx_wdata | input | 8 | Transmit word |
| tx_full | output | 1 | Transmit buffer occupied |
| rx_rd | input | 1 | Receive read strobe |
| rx_rdata | output | 8 | Last received word |
| rx_valid | output | 1 | Unread received word present |
| ovr_clr | input | 1 | Clears the overrun flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| busy | output | 1 | A transfer is in progress |
| irq | output | 1 | Single-cycle interrupt pulse |
| sck | output | 1 | Serial clock |
| so | output | 1 | Serial data out |
| si | input | 1 | Serial data in |

## Verification
On every cycle the embedded properties check four things:
- the prescaler and divider counters stay within their configured limits;
- `so` holds still in idle;
- `irq` never lasts two cycles;
- the transmit buffer and the overrun flag are not disturbed when they must hold.

Three things need the bench scenarios, because no single-cycle property can show them:
- the half-period lengths;
- the bit order and capture edge under both data phases;
- back-to-back continuous streaming and the overrun replacement.

The bench checks these with a serial slave model that samples `so` and drives `si` from queued words.

// File: rtl/csm_pkg.sv
package csm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REST   = 2'd1,
        ST_ACTIVE = 2'd2
    } csm_state_e;
endpackage

// File: rtl/csm_baud_tick.sv
module csm_baud_tick #(
    parameter int PRE_W     = 4,
    parameter int DIV_W     = 7,
    parameter bit FAST_DIV2 = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] pre_sel,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    localparam int PCNT_W = (1 << PRE_W) - 1;

    logic [PCNT_W-1:0] pcnt;
    logic [PCNT_W-1:0] pmask;
    logic [DIV_W-1:0]  dcnt;
    logic [DIV_W-1:0]  div_eff;
    logic              pre_tick;

    assign pmask = ~({PCNT_W{1'b1}} << pre_sel);

    generate
        if (FAST_DIV2) begin : g_fast
            assign div_eff = div_n;
        end else begin : g_slow
            assign div_eff = (div_n == '0) ? DIV_W'(1) : div_n;
        end
    endgenerate

    assign pre_tick = (pcnt == pmask);
    assign tick     = en && pre_tick && (dcnt == div_eff);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
            dcnt <= '0;
        end else if (!en) begin
            pcnt <= '0;
            dcnt <= '0;
        end else begin
            pcnt <= pre_tick ? '0 : pcnt + 1'b1;
            if (tick)
                dcnt <= '0;
            else if (pre_tick)
                dcnt <= dcnt + 1'b1;
        end
    end

    // R1: prescale counter never passes its configured terminal value
    p_prescale_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (pcnt <= pmask));

    // R1: divider counter never passes its configured terminal value
    p_divider_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (dcnt <= div_eff));
endmodule

// File: rtl/csm_shifter.sv
module csm_shifter
    import csm_pkg::*;
#(
    parameter int MAX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             have_word,
    input  logic [MAX_W-1:0] tx_word,
    input  logic             len_short,
    input  logic             lsb_first,
    input  logic             clk_inv,
    input  logic             early,
    input  logic             continuous,
    input  logic             si,
    output logic             sck,
    output logic             so,
    output logic             busy,
    output logic             load,
    output logic             word_end,
    output logic [MAX_W-1:0] rx_word
);
    localparam int CNT_W = $clog2(MAX_W);

    csm_state_e       state, state_n;
    logic [CNT_W-1:0] bitcnt;
    logic [CNT_W-1:0] last_idx;
    logic [MAX_W-1:0] txsh;
    logic [MAX_W-1:0] rxsh;
    logic             take_in;
    logic             advance;

    assign last_idx = len_short ? CNT_W'(MAX_W - 2) : CNT_W'(MAX_W - 1);

    function automatic logic [CNT_W-1:0] pos_of(input logic [CNT_W-1:0] k);
        return lsb_first ? k : CNT_W'(last_idx - k);
    endfunction

    // next-state and event decode
    always_comb begin
        state_n  = state;
        load     = 1'b0;
        take_in  = 1'b0;
        advance  = 1'b0;
        word_end = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (have_word) begin
                    load    = 1'b1;
                    state_n = early ? ST_REST : ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (tick) begin
                    state_n = ST_REST;
                    if (!early)
                        take_in = 1'b1;
                    else if (bitcnt == last_idx)
                        word_end = 1'b1;
                    else
                        advance = 1'b1;
                end
            end
            ST_REST: begin
                if (tick) begin
                    state_n = ST_ACTIVE;
                    if (early)
                        take_in = 1'b1;
                    else if (bitcnt == last_idx)
                        word_end = 1'b1;
                    else
                        advance = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (word_end) begin
            if (continuous && have_word) begin
                load    = 1'b1;
                state_n = early ? ST_REST : ST_ACTIVE;
            end else begin
                state_n = ST_IDLE;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    // datapath and serial output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            txsh   <= '0;
            rxsh   <= '0;
            so     <= 1'b0;
        end else if (load) begin
            bitcnt <= '0;
            txsh   <= tx_word;
            rxsh   <= '0;
            so     <= tx_word[lsb_first ? '0 : last_idx];
        end else begin
            if (advance) begin
                bitcnt <= bitcnt + 1'b1;
                so     <= txsh[pos_of(bitcnt + 1'b1)];
            end
            if (take_in)
                rxsh[pos_of(bitcnt)] <= si;
        end
    end

    assign busy    = (state != ST_IDLE);
    assign sck     = (state == ST_ACTIVE) ^ clk_inv;
    assign rx_word = rxsh;

    // R2: data line holds its last bit while the channel stays idle
    p_so_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> $stable(so));

    // R4: a load always leaves the idle state on the next cycle
    p_load_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state != ST_IDLE));
endmodule

// File: rtl/serial_master_chan.sv
module serial_master_chan
    import csm_pkg::*;
#(
    parameter int MAX_W     = 8,
    parameter int PRE_W     = 4,
    parameter int DIV_W     = 7,
    parameter bit FAST_DIV2 = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_len7,
    input  logic             cfg_lsb_first,
    input  logic             cfg_clk_inv,
    input  logic             cfg_early,
    input  logic             cfg_continuous,
    input  logic [PRE_W-1:0] cfg_prescale,
    input  logic [DIV_W-1:0] cfg_divider,
    input  logic             tx_wr,
    input  logic [MAX_W-1:0] tx_wdata,
    output logic             tx_full,
    input  logic             rx_rd,
    output logic [MAX_W-1:0] rx_rdata,
    output logic             rx_valid,
    input  logic             ovr_clr,
    output logic             ovr_flag,
    output logic             busy,
    output logic             irq,
    output logic             sck,
    output logic             so,
    input  logic             si
);
    logic [MAX_W-1:0] tx_buf;
    logic [MAX_W-1:0] rx_word;
    logic             tick;
    logic             load;
    logic             word_end;

    csm_baud_tick #(
        .PRE_W    (PRE_W),
        .DIV_W    (DIV_W),
        .FAST_DIV2(FAST_DIV2)
    ) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (busy),
        .pre_sel(cfg_prescale),
        .div_n  (cfg_divider),
        .tick   (tick)
    );

    csm_shifter #(
        .MAX_W(MAX_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .have_word (tx_full),
        .tx_word   (tx_buf),
        .len_short (cfg_len7),
        .lsb_first (cfg_lsb_first),
        .clk_inv   (cfg_clk_inv),
        .early     (cfg_early),
        .continuous(cfg_continuous),
        .si        (si),
        .sck       (sck),
        .so        (so),
        .busy      (busy),
        .load      (load),
        .word_end  (word_end),
        .rx_word   (rx_word)
    );

    // host buffers, error flag and interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf   <= '0;
            tx_full  <= 1'b0;
            rx_rdata <= '0;
            rx_valid <= 1'b0;
            ovr_flag <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (tx_wr && !tx_full) begin
                tx_buf  <= tx_wdata;
                tx_full <= 1'b1;
            end else if (load) begin
                tx_full <= 1'b0;
            end
            if (word_end) begin
                rx_rdata <= rx_word;
                rx_valid <= 1'b1;
            end else if (rx_rd) begin
                rx_valid <= 1'b0;
            end
            if (word_end && rx_valid && !rx_rd)
                ovr_flag <= 1'b1;
            else if (ovr_clr)
                ovr_flag <= 1'b0;
            irq <= cfg_continuous ? load : word_end;
        end
    end

    // R8: a write into an occupied buffer leaves its contents alone
    p_txbuf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && tx_wr) |=> $stable(tx_buf));

    // R6: interrupt is a single-cycle pulse
    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9: overrun flag persists until cleared
    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag);

    // R9: a finished word always leaves a valid received word
    p_rx_valid_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        word_end |=> rx_valid);
endmodule

// File: tb/serial_master_chan_test.sv
module serial_master_chan_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_len7 = 1'b0, cfg_lsb_first = 1'b0, cfg_clk_inv = 1'b0;
    logic       cfg_early = 1'b0, cfg_continuous = 1'b0;
    logic [3:0] cfg_prescale = 4'd0;
    logic [6:0] cfg_divider = 7'd1;
    logic       tx_wr = 1'b0, rx_rd = 1'b0, ovr_clr = 1'b0, si = 1'b0;
    logic [7:0] tx_wdata = 8'h00;
    logic       tx_full, rx_valid, ovr_flag, busy, irq, sck, so;
    logic [7:0] rx_rdata;

    always #10 clk = ~clk;

    serial_master_chan uut (
        .clk(clk), .rst_n(rst_n), .cfg_len7(cfg_len7), .cfg_lsb_first(cfg_lsb_first),
        .cfg_clk_inv(cfg_clk_inv), .cfg_early(cfg_early), .cfg_continuous(cfg_continuous),
        .cfg_prescale(cfg_prescale), .cfg_divider(cfg_divider), .tx_wr(tx_wr),
        .tx_wdata(tx_wdata), .tx_full(tx_full), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .rx_valid(rx_valid), .ovr_clr(ovr_clr), .ovr_flag(ovr_flag), .busy(busy),
        .irq(irq), .sck(sck), .so(so), .si(si)
    );

    int checks = 0, fails = 0;
    bit finished = 1'b0, mon_en = 1'b0, auto_rd = 1'b1;
    int exp_tx[$], sl_q[$], exp_rx[$];
    int sbit = 0, mo = 0, words_done = 0, busy_falls = 0, hcnt = 1;
    logic p_sck = 1'b0, p_busy = 1'b0, p_txf = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int wlen();
        return cfg_len7 ? 7 : 8;
    endfunction

    function automatic int wmask();
        return cfg_len7 ? 8'h7F : 8'hFF;
    endfunction

    function automatic int half_len();
        return (1 << cfg_prescale) * (cfg_divider + 1);
    endfunction

    function automatic logic bit_of(input int w, input int k);
        return cfg_lsb_first ? w[k] : w[wlen() - 1 - k];
    endfunction

    // behavioural reference: serial slave, timing and interrupt model, reader
    always @(negedge clk) begin
        if (mon_en) begin
            // R2 idle level of the serial clock
            if (!busy) chk(sck == cfg_clk_inv, "R2 sck rest level", sck, cfg_clk_inv);
            // R6 / R7 interrupt timing
            if (cfg_continuous)
                chk(irq == (p_txf && !tx_full), "R7 irq on buffer empty", irq, p_txf && !tx_full);
            else
                chk(irq == (p_busy && !busy), "R6 irq on transfer end", irq, p_busy && !busy);
            if (p_busy && !busy) busy_falls++;
            // R1 half-period length
            if (busy && !p_busy) begin
                hcnt = 1;
            end else if (sck != p_sck && p_busy) begin
                chk(hcnt == half_len(), "R1 half period", hcnt, half_len());
                hcnt = 1;
            end else begin
                hcnt++;
            end
            // slave model: capture so and advance si on the master's capture edge
            if (sck != p_sck && (p_busy || busy)) begin
                bit lead;
                lead = (sck != cfg_clk_inv);
                if (cfg_early ? lead : !lead) begin
                    int pos;
                    pos = cfg_lsb_first ? sbit : wlen() - 1 - sbit;
                    mo[pos] = so;
                    sbit++;
                    if (sbit == wlen()) begin
                        int e;
                        e = (exp_tx.size() != 0) ? exp_tx.pop_front() : -1;
                        chk(mo == e, cfg_early ? "R3/R5 serial word out" : "R3/R4 serial word out", mo, e);
                        if (sl_q.size() != 0) void'(sl_q.pop_front());
                        sbit = 0;
                        mo = 0;
                        words_done++;
                    end
                end
            end
            si = (sl_q.size() != 0) ? bit_of(sl_q[0], sbit) : 1'b0;
            // host reader
            if (auto_rd && rx_valid && !rx_rd) begin
                int e;
                e = (exp_rx.size() != 0) ? exp_rx.pop_front() : -1;
                chk(rx_rdata == e, "R3/R9 received word", rx_rdata, e);
                rx_rd = 1'b1;
            end else begin
                rx_rd = 1'b0;
            end
        end
        p_sck  = sck;
        p_busy = busy;
        p_txf  = tx_full;
    end

    task automatic send(input int w, input int sw);
        exp_tx.push_back(w & wmask());
        sl_q.push_back(sw & wmask());
        exp_rx.push_back(sw & wmask());
        while (tx_full) @(negedge clk);
        tx_wdata = 8'(w);
        tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || tx_full);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_cfg(input bit l7, input bit lsb, input bit inv, input bit erl,
                           input bit cont, input int pre, input int dv);
        cfg_len7 = l7; cfg_lsb_first = lsb; cfg_clk_inv = inv; cfg_early = erl;
        cfg_continuous = cont; cfg_prescale = 4'(pre); cfg_divider = 7'(dv);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(sck == 1'b0, "R10 reset sck", sck, 0);
        chk(so == 1'b0, "R10 reset so", so, 0);
        chk({busy, irq, tx_full, rx_valid, ovr_flag} == 5'b0, "R10 reset flags",
            {busy, irq, tx_full, rx_valid, ovr_flag}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;

        // normal phase, MSB first, 8 bits, half period 2
        set_cfg(0, 0, 0, 0, 0, 0, 1);
        send(8'hA5, 8'h5A);
        wait_idle();
        send(8'h3D, 8'hC3);
        wait_idle();
        chk(so == 1'b1, "R2 so holds last bit", so, 1);

        // early phase, LSB first, 7 bits, inverted clock, half period 12
        set_cfg(1, 1, 1, 1, 0, 2, 2);
        send(8'h55, 8'h2B);
        send(8'hFF, 8'h81);
        wait_idle();
        chk(so == 1'b1, "R2 so holds last bit 7-bit", so, 1);
        chk(rx_rdata[7] == 1'b0, "R3 7-bit rx top bit", rx_rdata[7], 0);

        // continuous, early phase, LSB first, half period 3
        set_cfg(0, 1, 0, 1, 1, 0, 2);
        busy_falls = 0;
        send(8'h12, 8'hF0);
        send(8'h34, 8'h0F);
        send(8'h56, 8'hAA);
        send(8'h78, 8'h55);
        wait_idle();
        chk(busy_falls == 1, "R7 back-to-back words", busy_falls, 1);

        // continuous, normal phase, fastest clock, 7 bits MSB first, inverted
        set_cfg(1, 0, 1, 0, 1, 0, 0);
        busy_falls = 0;
        send(8'h41, 8'h3E);
        send(8'h7F, 8'h01);
        send(8'h00, 8'h7F);
        wait_idle();
        chk(busy_falls == 1, "R7 back-to-back fast", busy_falls, 1);

        // R8 write while buffer occupied is ignored
        set_cfg(0, 0, 0, 0, 0, 1, 1);
        base = words_done;
        send(8'h11, 8'h99);
        while (!busy) @(negedge clk);
        send(8'h22, 8'h66);
        chk(tx_full == 1'b1, "R8 buffer occupied", tx_full, 1);
        tx_wdata = 8'h99;
        tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        wait_idle();
        chk(words_done - base == 2, "R8 ignored write", words_done - base, 2);
        chk(exp_tx.size() == 0, "R8 no extra word", exp_tx.size(), 0);

        // R9 overrun
        set_cfg(0, 0, 0, 0, 0, 0, 1);
        auto_rd = 1'b0;
        repeat (2) @(negedge clk);
        send(8'h81, 8'h18);
        wait_idle();
        chk(rx_valid == 1'b1 && ovr_flag == 1'b0, "R9 first word no overrun", ovr_flag, 0);
        send(8'h7E, 8'hE7);
        wait_idle();
        chk(ovr_flag == 1'b1, "R9 overrun set", ovr_flag, 1);
        chk(rx_rdata == 8'hE7, "R9 new word replaces", rx_rdata, 8'hE7);
        void'(exp_rx.pop_front());
        repeat (5) @(negedge clk);
        chk(ovr_flag == 1'b1, "R9 overrun sticky", ovr_flag, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk(ovr_flag == 1'b0, "R9 overrun cleared", ovr_flag, 0);
        auto_rd = 1'b1;
        repeat (4) @(negedge clk);
        chk(rx_valid == 1'b0, "R9 read clears valid", rx_valid, 0);
        chk(exp_rx.size() == 0 && exp_tx.size() == 0, "R3 all words accounted",
            exp_rx.size() + exp_tx.size(), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R10 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule